// File: doc/BRIEF.md
# Buffered Dual-Mode Output Compare Unit

This block holds four compare channels that watch one or two free-running up-counters, which are supplied from outside. Each channel has two registers. Software writes a staging register. A live register takes the staged value only when the channel's counter overflows, and only if software armed that channel's transfer beforehand. A live value of zero turns the channel's comparator off. When a channel's selected counter equals its live value, the channel raises a sticky flag. One shared enable gates the OR of all flags onto a single interrupt line.

A mode input sets which counter each channel watches. In single-counter mode every channel watches counter 1. In dual-counter mode the lower half of the channels (0 and 1) watch counter 1 and the upper half (2 and 3) watch counter 2. The overflow that triggers a staged transfer follows the same mapping. Software clears flags through a write-one-to-clear strobe. Each transfer request clears itself once its transfer has taken place.

Top module: `ocmp_unit`

## Requirements
- R1: After reset, every staging value, every live value, every flag and every pending transfer is 0, and `irq` is 0.
- R2: A write (`wrEn` high, channel number on `wrChan`, value on `wrData`) updates only that channel's staging register. The live value seen on `activeVals` (channel n at bits [12n+11:12n]) does not change.
- R3: A live value takes the staged value at the clock edge where the channel's overflow pulse is high and its transfer request is pending. An overflow with no request pending leaves the live value unchanged.
- R4: A `xferSet` bit sets that channel's pending request, visible on `xferPend`. The request clears at the edge where its transfer happens. If a new `xferSet` arrives on that same edge, the request stays pending.
- R5: Channels 0 and 1 transfer on `ovf1`. Channels 2 and 3 transfer on `ovf2` when `dualMode` is 1 and on `ovf1` when `dualMode` is 0.
- R6: When `dualMode` is 0, every channel compares with `cnt1`. The channel's flag in `cmpFlag` goes high on the clock edge after the cycle in which equality first appears.
- R7: When `dualMode` is 1, channels 0 and 1 compare with `cnt1` and channels 2 and 3 compare with `cnt2`. Channels 2 and 3 ignore `cnt1` in this mode.
- R8: A channel whose live value is 0 never sets its flag, even when its counter reads 0.
- R9: A match is detected once per counter value. If the counter holds the matching value, a flag that has been cleared stays clear. It sets again only after the counter leaves the value and then returns to it.
- R10: A flag stays high until a cycle with its `flagClr` bit set. If a new match and a clear fall on the same edge, the flag stays set.
- R11: `irq` is high exactly when `irqEn` is 1 and at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dualMode | input | 1 | 0: all channels on counter 1; 1: upper half on counter 2 |
| cnt1 | input | 12 | Counter 1 value |
| cnt2 | input | 12 | Counter 2 value |
| ovf1 | input | 1 | Counter 1 overflow pulse |
| ovf2 | input | 1 | Counter 2 overflow pulse |
| wrEn | input | 1 | Staging register write strobe |
| wrChan | input | 2 | Channel number for the write |
| wrData | input | 12 | Value written to staging |
| xferSet | input | 4 | Per-channel transfer request set strobes |
| flagClr | input | 4 | Per-channel write-one-to-clear flag strobes |
| irqEn | input | 1 | Compare interrupt enable |
| activeVals | output | 48 | Live compare values, channel n at [12n+11:12n] |
| xferPend | output | 4 | Pending transfer requests |
| cmpFlag | output | 4 | Sticky compare flags |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that a live value moves only on a transfer strobe and that a request clears once it is served. They also check that a flag rises only after an equality with a nonzero live value, that a flag cannot drop without a clear, and that the interrupt never rises while disabled. The channel-to-counter mapping in each mode and the choice of overflow for each transfer can only be shown by the bench's scenarios. The same holds for the once-per-value re-arm and the set-beats-clear orderings, because each depends on a specific sequence of counter values.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

  localparam int unsigned NUM_CH = 4;
  localparam int unsigned CH_W   = $clog2(NUM_CH);
  localparam int unsigned HALF   = NUM_CH / 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_CH-1:0] loadPre;
    logic [NUM_CH-1:0] doXfer;
  } ocmp_stb_t;

  // Upper half of the channels follows counter 2 in dual mode
  function automatic logic usesCnt2(input logic dual, input int unsigned ch);
    return dual && (ch >= HALF);
  endfunction

endpackage

// File: rtl/ocmp_datapath.sv
module ocmp_datapath
  import ocmp_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    dualMode,
  input  logic [CNT_W-1:0]        cnt1,
  input  logic [CNT_W-1:0]        cnt2,
  input  logic [CNT_W-1:0]        wrData,
  input  ocmp_stb_t               stb,
  output logic [NUM_CH-1:0]       eqNow,
  output logic [NUM_CH*CNT_W-1:0] activeFlat
);

  logic [CNT_W-1:0] preQ    [NUM_CH];
  logic [CNT_W-1:0] activeQ [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [CNT_W-1:0] selCnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        preQ[i]    <= '0;
        activeQ[i] <= '0;
      end else begin
        if (stb.loadPre[i]) preQ[i]    <= wrData;
        if (stb.doXfer[i])  activeQ[i] <= preQ[i];
      end
    end

    always_comb begin
      selCnt   = usesCnt2(dualMode, i) ? cnt2 : cnt1;
      eqNow[i] = (activeQ[i] != '0) && (selCnt == activeQ[i]);
    end

    assign activeFlat[i*CNT_W +: CNT_W] = activeQ[i];

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !stb.doXfer[i] |=> $stable(activeQ[i])); // R3
  end

endmodule

// File: rtl/ocmp_control.sv
module ocmp_control
  import ocmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dualMode,
  input  logic              ovf1,
  input  logic              ovf2,
  input  logic              wrEn,
  input  logic [CH_W-1:0]   wrChan,
  input  logic [NUM_CH-1:0] xferSet,
  input  logic [NUM_CH-1:0] flagClr,
  input  logic              irqEn,
  input  logic [NUM_CH-1:0] eqNow,
  output ocmp_stb_t         stb,
  output logic [NUM_CH-1:0] xferPend,
  output logic [NUM_CH-1:0] cmpFlag,
  output logic              irq
);

  logic [NUM_CH-1:0] xferQ;
  logic [NUM_CH-1:0] eqQ;
  logic [NUM_CH-1:0] flagQ;
  logic [NUM_CH-1:0] ovfSel;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign ovfSel[i]      = usesCnt2(dualMode, i) ? ovf2 : ovf1;
    assign stb.loadPre[i] = wrEn && (wrChan == CH_W'(i));
    assign stb.doXfer[i]  = xferQ[i] && ovfSel[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferQ <= '0;
      eqQ   <= '0;
      flagQ <= '0;
    end else begin
      xferQ <= xferSet | (xferQ & ~stb.doXfer);
      eqQ   <= eqNow;
      flagQ <= (flagQ & ~flagClr) | (eqNow & ~eqQ);
    end
  end

  assign xferPend = xferQ;
  assign cmpFlag  = flagQ;
  assign irq      = irqEn && (|flagQ);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_XFER_SELF_CLR: assert property (@(posedge clk) disable iff (!rstN)
      (stb.doXfer[i] && !xferSet[i]) |=> !xferQ[i]); // R4
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagQ[i]) |-> $past(eqNow[i])); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (flagQ[i] && !flagClr[i]) |=> flagQ[i]); // R10
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irq); // R11

endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
  import ocmp_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    dualMode,
  input  logic [CNT_W-1:0]        cnt1,
  input  logic [CNT_W-1:0]        cnt2,
  input  logic                    ovf1,
  input  logic                    ovf2,
  input  logic                    wrEn,
  input  logic [CH_W-1:0]         wrChan,
  input  logic [CNT_W-1:0]        wrData,
  input  logic [NUM_CH-1:0]       xferSet,
  input  logic [NUM_CH-1:0]       flagClr,
  input  logic                    irqEn,
  output logic [NUM_CH*CNT_W-1:0] activeVals,
  output logic [NUM_CH-1:0]       xferPend,
  output logic [NUM_CH-1:0]       cmpFlag,
  output logic                    irq
);

  ocmp_stb_t         stb;
  logic [NUM_CH-1:0] eqNow;

  ocmp_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dualMode (dualMode),
    .ovf1     (ovf1),
    .ovf2     (ovf2),
    .wrEn     (wrEn),
    .wrChan   (wrChan),
    .xferSet  (xferSet),
    .flagClr  (flagClr),
    .irqEn    (irqEn),
    .eqNow    (eqNow),
    .stb      (stb),
    .xferPend (xferPend),
    .cmpFlag  (cmpFlag),
    .irq      (irq)
  );

  ocmp_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dualMode   (dualMode),
    .cnt1       (cnt1),
    .cnt2       (cnt2),
    .wrData     (wrData),
    .stb        (stb),
    .eqNow      (eqNow),
    .activeFlat (activeVals)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_zero
    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rstN)
      $rose(cmpFlag[i]) |-> ($past(activeVals[i*CNT_W +: CNT_W]) != '0)); // R8
  end

endmodule

// File: tb/sim_ocmp_unit.sv
module sim_ocmp_unit;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int NCH = 4;

  logic            clk = 0;
  logic            rstN = 0;
  logic            dualMode = 0;
  logic [CW-1:0]   cnt1 = 0, cnt2 = 0;
  logic            ovf1 = 0, ovf2 = 0;
  logic            wrEn = 0;
  logic [1:0]      wrChan = 0;
  logic [CW-1:0]   wrData = 0;
  logic [NCH-1:0]  xferSet = 0, flagClr = 0;
  logic            irqEn = 0;
  logic [NCH*CW-1:0] activeVals;
  logic [NCH-1:0]  xferPend, cmpFlag;
  logic            irq;

  int nTests = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocmp_unit u0 (
    .clk(clk), .rstN(rstN), .dualMode(dualMode), .cnt1(cnt1), .cnt2(cnt2),
    .ovf1(ovf1), .ovf2(ovf2), .wrEn(wrEn), .wrChan(wrChan), .wrData(wrData),
    .xferSet(xferSet), .flagClr(flagClr), .irqEn(irqEn),
    .activeVals(activeVals), .xferPend(xferPend), .cmpFlag(cmpFlag), .irq(irq)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int liveOf(input int ch);
    return int'(activeVals[ch*CW +: CW]);
  endfunction

  task automatic writePre(input int ch, input int val);
    wrEn = 1; wrChan = 2'(ch); wrData = CW'(val);
    step();
    wrEn = 0;
  endtask

  task automatic armXfer(input logic [NCH-1:0] m);
    xferSet = m;
    step();
    xferSet = 0;
  endtask

  task automatic pulseOvf(input int which);
    if (which == 1) ovf1 = 1; else ovf2 = 1;
    step();
    ovf1 = 0; ovf2 = 0;
  endtask

  task automatic clearAll();
    flagClr = '1;
    step();
    flagClr = 0;
  endtask

  task automatic t_reset();
    check("R1 live", int'(activeVals), 0);
    check("R1 flags", int'(cmpFlag), 0);
    check("R1 pend", int'(xferPend), 0);
    check("R1 irq", int'(irq), 0);
  endtask

  task automatic t_buffer();
    writePre(0, 5);
    check("R2 live unchanged after write", liveOf(0), 0);
    pulseOvf(1);
    check("R3 overflow without request", liveOf(0), 0);
    armXfer(4'b0001);
    check("R4 request pending", int'(xferPend), 1);
    pulseOvf(1);
    check("R3 transfer on overflow", liveOf(0), 5);
    check("R4 request self-clears", int'(xferPend[0]), 0);
  endtask

  task automatic t_map();
    dualMode = 1;
    writePre(2, 7);
    armXfer(4'b0100);
    pulseOvf(1);
    check("R5 dual ch2 ignores ovf1", liveOf(2), 0);
    check("R5 dual ch2 still pending", int'(xferPend[2]), 1);
    pulseOvf(2);
    check("R5 dual ch2 on ovf2", liveOf(2), 7);
    dualMode = 0;
    writePre(3, 9);
    armXfer(4'b1000);
    pulseOvf(1);
    check("R5 single ch3 on ovf1", liveOf(3), 9);
  endtask

  task automatic t_setWins();
    writePre(1, 3);
    armXfer(4'b0010);
    ovf1 = 1; xferSet = 4'b0010;
    step();
    ovf1 = 0; xferSet = 0;
    check("R4 transfer with same-edge set", liveOf(1), 3);
    check("R4 set wins over self-clear", int'(xferPend[1]), 1);
    pulseOvf(1);
    check("R4 cleared after second transfer", int'(xferPend[1]), 0);
  endtask

  task automatic t_single();
    cnt1 = 5; step();
    check("R6 single ch0 match", int'(cmpFlag), 4'b0001);
    cnt1 = 7; step();
    check("R6 single ch2 on cnt1", int'(cmpFlag), 4'b0101);
    cnt1 = 9; step();
    check("R6 single ch3 on cnt1", int'(cmpFlag), 4'b1101);
    cnt1 = 3; step();
    check("R6 single ch1", int'(cmpFlag), 4'b1111);
    check("R11 irq disabled", int'(irq), 0);
    irqEn = 1; step();
    check("R11 irq enabled", int'(irq), 1);
  endtask

  task automatic t_once();
    clearAll();
    check("R10 clear all", int'(cmpFlag), 0);
    step(); step();
    check("R9 held value no re-set", int'(cmpFlag[1]), 0);
    check("R11 irq low without flags", int'(irq), 0);
    cnt1 = 4; step();
    cnt1 = 3; step();
    check("R9 re-arm after leaving", int'(cmpFlag[1]), 1);
    clearAll();
  endtask

  task automatic t_clrRace();
    cnt1 = 4; step();
    cnt1 = 5; flagClr = 4'b0001;
    step();
    flagClr = 0;
    check("R10 set beats clear", int'(cmpFlag[0]), 1);
    cnt1 = 6; step(); step();
    check("R10 flag sticky", int'(cmpFlag[0]), 1);
    clearAll();
  endtask

  task automatic t_dual();
    dualMode = 1; cnt1 = 7; cnt2 = 0;
    step();
    check("R7 dual ch2 ignores cnt1", int'(cmpFlag), 0);
    cnt2 = 7; step();
    check("R7 dual ch2 on cnt2", int'(cmpFlag), 4'b0100);
    cnt2 = 9; step();
    check("R7 dual ch3 on cnt2", int'(cmpFlag), 4'b1100);
  endtask

  task automatic t_zero();
    dualMode = 0; cnt1 = 1; flagClr = '1;
    step();
    flagClr = 0;
    writePre(1, 0);
    armXfer(4'b0010);
    pulseOvf(1);
    check("R8 ch1 live zero", liveOf(1), 0);
    cnt1 = 0; step(); step();
    check("R8 zero live never matches", int'(cmpFlag), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    step(); step(); step();
    rstN = 1;
    step();
    t_reset();
    t_buffer();
    t_map();
    t_setWins();
    t_single();
    t_once();
    t_clrRace();
    t_dual();
    t_zero();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule